// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the output stage of one programmable-logic cell. It receives a sum-of-products term from the logic array and a value straight from an input pad. A static configuration chooses how that data is used. It can drive the output combinationally, or hold it in an edge-triggered D flip-flop, a toggle flip-flop or a level-sensitive latch. The same configuration also chooses the cell clock, its polarity, single-edge or dual-edge capture, the power-up value, how the cell answers the chip-wide set/reset line, and where the output enable comes from.

All the logic runs on one fast system clock, `clk`. The global clocks and the locally formed clock are treated as level signals and sampled by `clk`. An edge of the chosen cell clock is detected when its phase-adjusted level differs from the level seen at the previous `clk` edge. The stored value changes at that same `clk` edge. The set and reset inputs act at the next `clk` edge whether or not a cell-clock edge occurs. Configuration is captured only while `rst` is high, and the stored bit is loaded with the configured power-up value at the same time.

Top module: `mcell_store`

## Requirements
- R1: The configuration inputs are captured only on `clk` edges where `rst` is high. Changing them while `rst` is low has no effect on `q` or `oe`.
- R2: A `clk` edge with `rst` high loads the stored bit with `cfg_init`. In the storage modes that bit is visible on `q` after the edge.
- R3: In D flip-flop mode (`cfg_mode` = 01), an active cell-clock edge with `pt_ce` high loads the stored bit with the selected data.
- R4: In toggle mode (`cfg_mode` = 10), an active cell-clock edge with `pt_ce` high inverts the stored bit when the selected data is 1. When the data is 0, the bit holds.
- R5: In latch mode (`cfg_mode` = 11), the stored bit takes the selected data on every `clk` edge where the phase-adjusted cell clock is high and `pt_ce` is high. It holds while that clock is low.
- R6: With `pt_ce` low, active cell-clock edges leave the stored bit unchanged in every storage mode.
- R7: `cfg_cksel` value i (below NUM_GCK) selects `gclk[i]`, and value NUM_GCK selects `pt_clk`. With `cfg_ckinv` = 0 the rising edge is active. With `cfg_ckinv` = 1 the falling edge is active.
- R8: With `cfg_dual` = 1, both edges of the phase-adjusted cell clock are active.
- R9: The forcing inputs override clocked updates and the clock enable. The asynchronous set and reset inputs are `lrst`, `lset`, and `gsr` gated by `cfg_gsr_en`. `gsr` sets the bit when `cfg_gsr_set` = 1 and clears it otherwise, and it has no effect when `cfg_gsr_en` = 0. Any active clear beats any active set.
- R10: In combinational mode (`cfg_mode` = 00), `q` equals the selected data in the same cycle, with no clock edge needed.
- R11: `cfg_dsrc` = 0 selects `pt_sum` as the data, and `cfg_dsrc` = 1 selects `pin_in`.
- R12: `cfg_oesel` chooses `oe` as follows. 00 gives `goe[cfg_goe_idx]`, 01 gives `pt_oe`, 10 gives `mc_oe`, and 11 holds `oe` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples everything |
| rst | input | 1 | Synchronous active-high reset, captures configuration and loads power-up value |
| cfg_mode | input | 2 | Storage mode: 00 comb, 01 D, 10 toggle, 11 latch |
| cfg_dsrc | input | 1 | Data source: 0 product term, 1 pad |
| cfg_cksel | input | CKSEL_W | Cell clock source index |
| cfg_ckinv | input | 1 | Invert the cell clock |
| cfg_dual | input | 1 | Capture on both cell-clock edges |
| cfg_init | input | 1 | Power-up value |
| cfg_gsr_en | input | 1 | Cell obeys the global set/reset line |
| cfg_gsr_set | input | 1 | Global line sets (1) or clears (0) the cell |
| cfg_oesel | input | 2 | Output-enable source |
| cfg_goe_idx | input | GOE_W | Which global output enable to use |
| pt_sum | input | 1 | Sum-of-products data from the array |
| pin_in | input | 1 | Direct pad data |
| gclk | input | NUM_GCK | Global clock levels |
| pt_clk | input | 1 | Locally formed clock level |
| pt_ce | input | 1 | Clock enable |
| lset | input | 1 | Local asynchronous set |
| lrst | input | 1 | Local asynchronous reset |
| gsr | input | 1 | Global set/reset line |
| goe | input | NUM_GOE | Global output enables |
| pt_oe | input | 1 | Product-term output enable |
| mc_oe | input | 1 | Enable driven by another cell |
| q | output | 1 | Cell output data |
| oe | output | 1 | Cell output enable |

## Verification
Two collisions matter most. The first is an active cell-clock edge in the same cycle as a forcing input. The bench raises the selected clock while `lrst` is high and the data is 1, and expects 0. It also checks that the bit stays 0 on the following cycle, when no edge occurs. The second is a clear and a set requested together: local set with local reset, and the global line in set direction with local reset. In both cases the bench expects the cleared value on `q`.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    typedef enum logic [1:0] {
        MODE_COMB  = 2'b00,
        MODE_DFF   = 2'b01,
        MODE_TFF   = 2'b10,
        MODE_LATCH = 2'b11
    } store_mode_e;

    typedef enum logic [1:0] {
        OE_GLOBAL = 2'b00,
        OE_PTERM  = 2'b01,
        OE_CELL   = 2'b10,
        OE_ON     = 2'b11
    } oe_src_e;

    // Width-independent configuration fields of one cell.
    typedef struct packed {
        store_mode_e mode;
        logic        dsrc_pin;
        logic        ckinv;
        logic        dual;
        logic        init;
        logic        gsr_en;
        logic        gsr_set;
        oe_src_e     oesel;
    } cell_cfg_t;

    // Next stored value when no forcing input is active.
    function automatic logic next_bit(store_mode_e m, logic cur, logic d,
                                      logic hit, logic gate_open, logic en);
        logic nxt;
        nxt = cur;
        unique case (m)
            MODE_DFF:   if (hit && en) nxt = d;
            MODE_TFF:   if (hit && en && d) nxt = ~cur;
            MODE_LATCH: if (gate_open && en) nxt = d;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/mcell_cfg_reg.sv
module mcell_cfg_reg
    import mcell_pkg::*;
#(
    parameter int CKSEL_W = 2,
    parameter int GOE_W   = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  cell_cfg_t          cfg_in,
    input  logic [CKSEL_W-1:0] cksel_in,
    input  logic [GOE_W-1:0]   goe_idx_in,
    output cell_cfg_t          cfg_q,
    output logic [CKSEL_W-1:0] cksel_q,
    output logic [GOE_W-1:0]   goe_idx_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= cfg_in;
            cksel_q   <= cksel_in;
            goe_idx_q <= goe_idx_in;
        end
    end

endmodule

// File: rtl/mcell_clk_sel.sv
module mcell_clk_sel #(
    parameter int NUM_GCK = 3,
    parameter int CKSEL_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_GCK-1:0] gclk,
    input  logic               pt_clk,
    input  logic [CKSEL_W-1:0] cksel_raw,
    input  logic               ckinv_raw,
    input  logic [CKSEL_W-1:0] cksel,
    input  logic               ckinv,
    input  logic               dual,
    output logic               hit,
    output logic               gate_open
);

    logic raw_lvl, raw_pre, lvl, pre_lvl, prev_lvl, rise, fall;

    always_comb begin
        raw_lvl = pt_clk;
        raw_pre = pt_clk;
        for (int i = 0; i < NUM_GCK; i++) begin
            if (cksel == CKSEL_W'(i))     raw_lvl = gclk[i];
            if (cksel_raw == CKSEL_W'(i)) raw_pre = gclk[i];
        end
    end

    assign lvl     = raw_lvl ^ ckinv;
    assign pre_lvl = raw_pre ^ ckinv_raw;

    // During reset the history follows the configuration being loaded,
    // so the first cycle after reset sees no false edge.
    always_ff @(posedge clk) begin
        if (rst) prev_lvl <= pre_lvl;
        else     prev_lvl <= lvl;
    end

    assign rise      = lvl & ~prev_lvl;
    assign fall      = ~lvl & prev_lvl;
    assign hit       = dual ? (rise | fall) : rise;
    assign gate_open = lvl;

endmodule

// File: rtl/mcell_core.sv
module mcell_core
    import mcell_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init_raw,
    input  store_mode_e mode,
    input  logic        en,
    input  logic        d,
    input  logic        hit,
    input  logic        gate_open,
    input  logic        force_set,
    input  logic        force_clr,
    output logic        st
);

    always_ff @(posedge clk) begin
        if (rst)            st <= init_raw;
        else if (force_clr) st <= 1'b0;
        else if (force_set) st <= 1'b1;
        else                st <= next_bit(mode, st, d, hit, gate_open, en);
    end

endmodule

// File: rtl/mcell_store.sv
module mcell_store
    import mcell_pkg::*;
#(
    parameter int  NUM_GCK = 3,
    parameter int  NUM_GOE = 2,
    localparam int CKSEL_W = $clog2(NUM_GCK + 1),
    localparam int GOE_W   = (NUM_GOE > 1) ? $clog2(NUM_GOE) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_dsrc,
    input  logic [CKSEL_W-1:0] cfg_cksel,
    input  logic               cfg_ckinv,
    input  logic               cfg_dual,
    input  logic               cfg_init,
    input  logic               cfg_gsr_en,
    input  logic               cfg_gsr_set,
    input  logic [1:0]         cfg_oesel,
    input  logic [GOE_W-1:0]   cfg_goe_idx,
    input  logic               pt_sum,
    input  logic               pin_in,
    input  logic [NUM_GCK-1:0] gclk,
    input  logic               pt_clk,
    input  logic               pt_ce,
    input  logic               lset,
    input  logic               lrst,
    input  logic               gsr,
    input  logic [NUM_GOE-1:0] goe,
    input  logic               pt_oe,
    input  logic               mc_oe,
    output logic               q,
    output logic               oe
);

    cell_cfg_t          cfg_raw, cfg_q;
    logic [CKSEL_W-1:0] cksel_q;
    logic [GOE_W-1:0]   goe_idx_q;
    logic               hit, gate_open, d_sel, st;
    logic               force_set, force_clr, goe_pick;

    always_comb begin
        cfg_raw.mode     = store_mode_e'(cfg_mode);
        cfg_raw.dsrc_pin = cfg_dsrc;
        cfg_raw.ckinv    = cfg_ckinv;
        cfg_raw.dual     = cfg_dual;
        cfg_raw.init     = cfg_init;
        cfg_raw.gsr_en   = cfg_gsr_en;
        cfg_raw.gsr_set  = cfg_gsr_set;
        cfg_raw.oesel    = oe_src_e'(cfg_oesel);
    end

    mcell_cfg_reg #(.CKSEL_W(CKSEL_W), .GOE_W(GOE_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_in     (cfg_raw),
        .cksel_in   (cfg_cksel),
        .goe_idx_in (cfg_goe_idx),
        .cfg_q      (cfg_q),
        .cksel_q    (cksel_q),
        .goe_idx_q  (goe_idx_q)
    );

    mcell_clk_sel #(.NUM_GCK(NUM_GCK), .CKSEL_W(CKSEL_W)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .gclk      (gclk),
        .pt_clk    (pt_clk),
        .cksel_raw (cfg_cksel),
        .ckinv_raw (cfg_ckinv),
        .cksel     (cksel_q),
        .ckinv     (cfg_q.ckinv),
        .dual      (cfg_q.dual),
        .hit       (hit),
        .gate_open (gate_open)
    );

    assign d_sel     = cfg_q.dsrc_pin ? pin_in : pt_sum;
    assign force_clr = lrst | (gsr & cfg_q.gsr_en & ~cfg_q.gsr_set);
    assign force_set = lset | (gsr & cfg_q.gsr_en & cfg_q.gsr_set);

    mcell_core u_core (
        .clk       (clk),
        .rst       (rst),
        .init_raw  (cfg_init),
        .mode      (cfg_q.mode),
        .en        (pt_ce),
        .d         (d_sel),
        .hit       (hit),
        .gate_open (gate_open),
        .force_set (force_set),
        .force_clr (force_clr),
        .st        (st)
    );

    assign q = (cfg_q.mode == MODE_COMB) ? d_sel : st;

    always_comb begin
        goe_pick = goe[0];
        for (int i = 0; i < NUM_GOE; i++)
            if (goe_idx_q == GOE_W'(i)) goe_pick = goe[i];
    end

    always_comb begin
        unique case (cfg_q.oesel)
            OE_GLOBAL: oe = goe_pick;
            OE_PTERM:  oe = pt_oe;
            OE_CELL:   oe = mc_oe;
            default:   oe = 1'b1;
        endcase
    end

endmodule

// File: rtl/mcell_store_chk.sv
module mcell_store_chk
    import mcell_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input cell_cfg_t cfg_q,
    input logic      st,
    input logic      q,
    input logic      d_sel,
    input logic      hit,
    input logic      ce,
    input logic      lset,
    input logic      lrst,
    input logic      gsr
);

    logic want_clr, want_set, quiet;
    assign want_clr = lrst | (gsr & cfg_q.gsr_en & ~cfg_q.gsr_set);
    assign want_set = lset | (gsr & cfg_q.gsr_en & cfg_q.gsr_set);
    assign quiet    = !want_clr && !want_set;

    a_r2_init_load: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> st == cfg_q.init);

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
        want_clr |=> !st);

    a_r9_set_applies: assert property (@(posedge clk) disable iff (rst)
        (want_set && !want_clr) |=> st);

    a_r6_ce_hold: assert property (@(posedge clk) disable iff (rst)
        (quiet && !ce && cfg_q.mode != MODE_LATCH) |=> $stable(st));

    a_r3_dff_capture: assert property (@(posedge clk) disable iff (rst)
        (quiet && ce && hit && cfg_q.mode == MODE_DFF) |=> st == $past(d_sel));

    a_r4_tff_toggle: assert property (@(posedge clk) disable iff (rst)
        (quiet && ce && hit && d_sel && cfg_q.mode == MODE_TFF) |=> st != $past(st));

    a_r10_comb_pass: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_COMB) |-> q == d_sel);

endmodule

bind mcell_store mcell_store_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .cfg_q (cfg_q),
    .st    (st),
    .q     (q),
    .d_sel (d_sel),
    .hit   (hit),
    .ce    (pt_ce),
    .lset  (lset),
    .lrst  (lrst),
    .gsr   (gsr)
);

// File: tb/mcell_store_test.sv
module mcell_store_test;
    import mcell_pkg::*;

    localparam int NUM_GCK = 3;
    localparam int NUM_GOE = 2;
    localparam int CKSEL_W = 2;
    localparam int GOE_W   = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cfg_mode = 2'b01;
    logic cfg_dsrc = 0, cfg_ckinv = 0, cfg_dual = 0, cfg_init = 0;
    logic cfg_gsr_en = 0, cfg_gsr_set = 0;
    logic [1:0] cfg_oesel = 2'b11;
    logic [CKSEL_W-1:0] cfg_cksel = '0;
    logic [GOE_W-1:0] cfg_goe_idx = '0;
    logic pt_sum = 0, pin_in = 0, pt_clk = 0, pt_ce = 1;
    logic lset = 0, lrst = 0, gsr = 0, pt_oe = 0, mc_oe = 0;
    logic [NUM_GCK-1:0] gclk = '0;
    logic [NUM_GOE-1:0] goe = '0;
    logic q, oe;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mcell_store #(.NUM_GCK(NUM_GCK), .NUM_GOE(NUM_GOE)) uut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_dsrc(cfg_dsrc),
        .cfg_cksel(cfg_cksel), .cfg_ckinv(cfg_ckinv), .cfg_dual(cfg_dual),
        .cfg_init(cfg_init), .cfg_gsr_en(cfg_gsr_en), .cfg_gsr_set(cfg_gsr_set),
        .cfg_oesel(cfg_oesel), .cfg_goe_idx(cfg_goe_idx), .pt_sum(pt_sum),
        .pin_in(pin_in), .gclk(gclk), .pt_clk(pt_clk), .pt_ce(pt_ce),
        .lset(lset), .lrst(lrst), .gsr(gsr), .goe(goe), .pt_oe(pt_oe),
        .mc_oe(mc_oe), .q(q), .oe(oe)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_all();
        cfg_mode = MODE_DFF; cfg_dsrc = 0; cfg_cksel = '0; cfg_ckinv = 0;
        cfg_dual = 0; cfg_init = 0; cfg_gsr_en = 0; cfg_gsr_set = 0;
        cfg_oesel = OE_ON; cfg_goe_idx = '0;
        pt_sum = 0; pin_in = 0; pt_clk = 0; pt_ce = 1;
        lset = 0; lrst = 0; gsr = 0; pt_oe = 0; mc_oe = 0;
        gclk = '0; goe = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        clear_all(); cfg_init = 1; do_reset();
        chk("R2 init one", q, 1'b1);
        clear_all(); cfg_init = 0; do_reset();
        chk("R2 init zero", q, 1'b0);
    endtask

    task automatic t_dff();
        clear_all(); do_reset();
        pt_sum = 1; tick();
        chk("R3 no edge holds", q, 1'b0);
        gclk[0] = 1; tick();
        chk("R3 rise captures", q, 1'b1);
        pt_sum = 0; tick();
        chk("R3 level high holds", q, 1'b1);
        gclk[0] = 0; tick();
        chk("R7 falling edge inactive", q, 1'b1);
        gclk[0] = 1; tick();
        chk("R3 rise captures zero", q, 1'b0);
    endtask

    task automatic t_cksel();
        clear_all(); cfg_cksel = 2'd2; do_reset();
        pt_sum = 1; gclk[0] = 1; tick();
        chk("R7 unselected clock ignored", q, 1'b0);
        gclk[2] = 1; tick();
        chk("R7 gclk2 selected", q, 1'b1);
        clear_all(); cfg_cksel = 2'd3; do_reset();
        pt_sum = 1; gclk[0] = 1; tick();
        chk("R7 local sel ignores gclk0", q, 1'b0);
        pt_clk = 1; tick();
        chk("R7 local clock captures", q, 1'b1);
        clear_all(); cfg_ckinv = 1; do_reset();
        pt_sum = 1; gclk[0] = 1; tick();
        chk("R7 inverted rise inactive", q, 1'b0);
        gclk[0] = 0; tick();
        chk("R7 inverted fall captures", q, 1'b1);
    endtask

    task automatic t_tff();
        clear_all(); cfg_mode = MODE_TFF; do_reset();
        pt_sum = 1; gclk[0] = 1; tick();
        chk("R4 toggle to one", q, 1'b1);
        gclk[0] = 0; tick();
        gclk[0] = 1; tick();
        chk("R4 toggle to zero", q, 1'b0);
        pt_sum = 0; gclk[0] = 0; tick();
        gclk[0] = 1; tick();
        chk("R4 data zero holds", q, 1'b0);
    endtask

    task automatic t_latch();
        clear_all(); cfg_mode = MODE_LATCH; do_reset();
        pt_sum = 1; tick();
        chk("R5 closed holds", q, 1'b0);
        gclk[0] = 1; tick();
        chk("R5 open takes data", q, 1'b1);
        pt_sum = 0; tick();
        chk("R5 open follows", q, 1'b0);
        gclk[0] = 0; pt_sum = 1; tick();
        chk("R5 closed ignores data", q, 1'b0);
    endtask

    task automatic t_ce();
        clear_all(); do_reset();
        pt_ce = 0; pt_sum = 1; gclk[0] = 1; tick();
        chk("R6 enable low ignores edge", q, 1'b0);
        pt_ce = 1; tick();
        chk("R6 no late capture", q, 1'b0);
        clear_all(); cfg_mode = MODE_TFF; do_reset();
        pt_ce = 0; pt_sum = 1; gclk[0] = 1; tick();
        chk("R6 toggle blocked", q, 1'b0);
    endtask

    task automatic t_dual();
        clear_all(); cfg_dual = 1; do_reset();
        pt_sum = 1; gclk[0] = 1; tick();
        chk("R8 rise captures", q, 1'b1);
        pt_sum = 0; tick();
        chk("R8 no edge holds", q, 1'b1);
        gclk[0] = 0; tick();
        chk("R8 fall captures", q, 1'b0);
    endtask

    task automatic t_async();
        clear_all(); do_reset();
        lset = 1; tick();
        chk("R9 local set", q, 1'b1);
        lset = 0; lrst = 1; tick();
        chk("R9 local reset", q, 1'b0);
        lset = 1; tick();
        chk("R9 reset beats set", q, 1'b0);
        lrst = 0; tick(); lset = 0;
        gsr = 1; tick();
        chk("R9 global ignored when not enabled", q, 1'b1);
        clear_all(); cfg_gsr_en = 1; cfg_gsr_set = 1; do_reset();
        gsr = 1; tick();
        chk("R9 global set", q, 1'b1);
        gsr = 0; lrst = 1; tick();
        gsr = 1; tick();
        chk("R9 local reset beats global set", q, 1'b0);
        clear_all(); cfg_gsr_en = 1; cfg_init = 1; do_reset();
        gsr = 1; tick();
        chk("R9 global reset", q, 1'b0);
        clear_all(); do_reset();
        pt_sum = 1; lrst = 1; gclk[0] = 1; tick();
        chk("R9 reset beats clock edge", q, 1'b0);
        lrst = 0; tick();
        chk("R9 edge not replayed", q, 1'b0);
    endtask

    task automatic t_comb();
        clear_all(); cfg_mode = MODE_COMB; do_reset();
        pt_sum = 1; #1;
        chk("R10 pass one", q, 1'b1);
        pt_sum = 0; #1;
        chk("R10 pass zero", q, 1'b0);
        tick();
    endtask

    task automatic t_dsrc();
        clear_all(); cfg_dsrc = 1; do_reset();
        pin_in = 1; gclk[0] = 1; tick();
        chk("R11 pad data captured", q, 1'b1);
        pin_in = 0; pt_sum = 1; gclk[0] = 0; tick();
        gclk[0] = 1; tick();
        chk("R11 array data ignored", q, 1'b0);
    endtask

    task automatic t_oe();
        clear_all(); cfg_oesel = OE_GLOBAL; cfg_goe_idx = 1'b1; do_reset();
        goe = 2'b10; #1;
        chk("R12 global index one high", oe, 1'b1);
        goe = 2'b01; #1;
        chk("R12 global index one low", oe, 1'b0);
        clear_all(); cfg_oesel = OE_PTERM; do_reset();
        pt_oe = 1; #1;
        chk("R12 pterm enable", oe, 1'b1);
        pt_oe = 0; mc_oe = 1; #1;
        chk("R12 pterm enable low", oe, 1'b0);
        clear_all(); cfg_oesel = OE_CELL; do_reset();
        mc_oe = 1; #1;
        chk("R12 cell enable", oe, 1'b1);
        clear_all(); cfg_oesel = OE_ON; do_reset();
        #1;
        chk("R12 always on", oe, 1'b1);
        tick();
    endtask

    task automatic t_cfg_static();
        clear_all(); do_reset();
        cfg_mode = MODE_COMB; cfg_init = 1; cfg_oesel = OE_PTERM;
        pt_sum = 1; tick();
        chk("R1 mode change ignored", q, 1'b0);
        chk("R1 oe select change ignored", oe, 1'b1);
        gclk[0] = 1; tick();
        chk("R1 still clocked storage", q, 1'b1);
    endtask

    initial begin
        repeat (2) tick();
        t_reset();
        t_dff();
        t_cksel();
        t_tff();
        t_latch();
        t_ce();
        t_dual();
        t_async();
        t_comb();
        t_dsrc();
        t_oe();
        t_cfg_static();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule